// File: doc/BRIEF.md
# Software-Loaded Translation Buffer with Staging Registers

This block is a fully associative address-translation buffer, 32 entries by default, that software fills one entry at a time. Software first writes the staging registers for the entry: the virtual page register, which holds the page number, an entry-valid flag and an address-space tag, and the attribute register, which holds the page size, the guarded flag, the access group and a segment-valid flag. It also writes the control register when it needs to choose the target slot. A write to the physical-page register then commits the combined entry into the slot that the control register names. After each commit the slot pointer moves on by one, so that consecutive loads fill the table in order.

A separate register holds the current address-space tag. Each cycle the lookup port takes an effective page number (address bits 31:12) and compares it with every entry in parallel. It returns a hit flag, the physical page number with the in-page bits of large pages merged back in, and the attributes of the matching entry. A control bit can keep the four lowest slots out of the automatic wrap, so that software can pin those entries.

Top module: `sw_tlb`

## Requirements
- R1: After reset the control register reads back CTRL_RESET (default 0x0400_0000, the slot field included), every entry is invalid, and no lookup hits.
- R2: Register selects are 0 control, 1 virtual page, 2 attribute, 3 address-space, 4 physical page. The virtual page, attribute and physical page registers read back exactly as written. The address-space register keeps only bits 3:0. The control register reads back as written except bits 12:8, which show the current slot pointer.
- R3: A write to select 4 commits one entry into the slot held in control bits 12:8. The entry takes the page number from virtual page bits 31:12, the tag from bits 3:0, the size from attribute bits 3:2, guarded from bit 4, the group from bits 8:5, and the physical page from the written data bits 31:12.
- R4: Each commit advances the slot pointer by one. From the last slot it wraps to 0 when the reserve bit is clear.
- R5: Control bit 27 is the reserve bit. While it is set, the wrap from the last slot goes to slot 4 instead of 0. Slots 0 to 3 can still be written when software explicitly loads their index into the control register.
- R6: A lookup hits only when the entry is valid and its tag equals the current address-space register bits 3:0.
- R7: Size code 00 (4 KB) compares page bits 19:0, code 01 (512 KB) compares bits 19:7, and code 11 (8 MB) compares bits 19:11. The unassigned code 10 behaves as 4 KB.
- R8: On a hit the physical page number takes the entry's physical page in the compared bit positions and the lookup page in the bit positions that are not compared.
- R9: On a hit the guarded flag, group and size outputs show the matching entry's fields.
- R10: When several entries match, the lowest-numbered slot wins.
- R11: A lookup in the cycle after a commit sees the new entry, and the entry it replaced no longer matches.
- R12: An entry is valid only when both virtual page bit 9 and attribute bit 0 were set at commit. Committing with either flag clear invalidates the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for readback |
| rd_data | output | 32 | Readback data, combinational |
| lk_page | input | 20 | Effective page number to translate (address bits 31:12) |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_ppn | output | 20 | Translated physical page number |
| lk_guarded | output | 1 | Guarded flag of the matching entry |
| lk_group | output | 4 | Access group of the matching entry |
| lk_size | output | 2 | Page size code of the matching entry |

## Verification
A wrong slot pointer shows up on the control readback in the cycle right after a commit. The entry it misplaced surfaces at the next lookup, either as a miss or as a physical page that belongs to another slot. A corrupted stored field appears on the lookup outputs in that same following cycle. A bad size mask reveals itself only when the bench sweeps the in-page bits of a large page, or steps just past its boundary. A priority fault needs two entries that match the same page.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;

   localparam int PAGE_W = 20;
   localparam int TAG_W  = 4;
   localparam int GRP_W  = 4;

   // register selects
   localparam logic [2:0] SEL_CTRL = 3'd0;
   localparam logic [2:0] SEL_VPG  = 3'd1;
   localparam logic [2:0] SEL_ATTR = 3'd2;
   localparam logic [2:0] SEL_TAG  = 3'd3;
   localparam logic [2:0] SEL_PPG  = 3'd4;

   // page size codes
   localparam logic [1:0] SZ_4K   = 2'b00;
   localparam logic [1:0] SZ_512K = 2'b01;
   localparam logic [1:0] SZ_8M   = 2'b11;

   typedef struct packed {
      logic              vld;
      logic [PAGE_W-1:0] vpn;
      logic [TAG_W-1:0]  tag;
      logic [1:0]        size;
      logic              grd;
      logic [GRP_W-1:0]  grp;
      logic [PAGE_W-1:0] ppn;
   } tlb_entry_t;

   // bits of the page number that take part in the compare
   function automatic logic [PAGE_W-1:0] cmp_mask(input logic [1:0] sz);
      logic [PAGE_W-1:0] m;
      m = '1;
      case (sz)
         SZ_512K: m = {{(PAGE_W-7){1'b1}}, 7'b0};
         SZ_8M:   m = {{(PAGE_W-11){1'b1}}, 11'b0};
         default: m = '1;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/tlb_stage_regs.sv
module tlb_stage_regs
   import sw_tlb_pkg::*;
#(
   parameter int          ENTRIES    = 32,
   parameter int          RESERVED   = 4,
   parameter logic [31:0] CTRL_RESET = 32'h0400_0000,
   parameter int          INDEX_LSB  = 8,
   parameter int          FIELD_W    = 5,
   parameter int          RSV_BIT    = 27,
   localparam int         IDX_W      = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [31:0]      wr_data,
   input  logic [2:0]       rd_sel,
   output logic [31:0]      rd_data,
   output logic [TAG_W-1:0] cur_tag,
   output logic             commit,
   output logic [IDX_W-1:0] commit_idx,
   output tlb_entry_t       commit_entry
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
   localparam logic [IDX_W-1:0] RSV_IDX  = IDX_W'(RESERVED);
   localparam logic [IDX_W-1:0] RST_IDX  = CTRL_RESET[INDEX_LSB +: IDX_W];

   generate
      if (ENTRIES < 2 || ENTRIES != (1 << IDX_W))
         $error("tlb_stage_regs: ENTRIES must be a power of two, at least 2");
      if (IDX_W > FIELD_W)
         $error("tlb_stage_regs: slot index does not fit the control field");
      if (RESERVED >= ENTRIES)
         $error("tlb_stage_regs: RESERVED must be below ENTRIES");
      if (RSV_BIT > 31 || INDEX_LSB + FIELD_W > 32)
         $error("tlb_stage_regs: control field positions out of range");
   endgenerate

   logic [31:0]      ctrl_q, vpg_q, attr_q, ppg_q;
   logic [TAG_W-1:0] tag_q;
   logic [IDX_W-1:0] idx_q, idx_nxt;
   logic [31:0]      ctrl_rd;
   logic             rsv;

   assign rsv    = ctrl_q[RSV_BIT];
   assign commit = wr_en && (wr_sel == SEL_PPG);

   // slot pointer after a commit
   always_comb begin
      if (idx_q == LAST_IDX) idx_nxt = rsv ? RSV_IDX : '0;
      else                   idx_nxt = idx_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
         idx_q  <= RST_IDX;
         vpg_q  <= '0;
         attr_q <= '0;
         ppg_q  <= '0;
         tag_q  <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_CTRL: begin
               ctrl_q <= wr_data;
               idx_q  <= wr_data[INDEX_LSB +: IDX_W];
            end
            SEL_VPG:  vpg_q  <= wr_data;
            SEL_ATTR: attr_q <= wr_data;
            SEL_TAG:  tag_q  <= wr_data[TAG_W-1:0];
            SEL_PPG: begin
               ppg_q <= wr_data;
               idx_q <= idx_nxt;
            end
            default: ;
         endcase
      end
   end

   // entry assembled from the staged fields plus the incoming page
   always_comb begin
      commit_entry.vld  = vpg_q[9] & attr_q[0];
      commit_entry.vpn  = vpg_q[31:12];
      commit_entry.tag  = vpg_q[TAG_W-1:0];
      commit_entry.size = attr_q[3:2];
      commit_entry.grd  = attr_q[4];
      commit_entry.grp  = attr_q[8:5];
      commit_entry.ppn  = wr_data[31:12];
   end
   assign commit_idx = idx_q;
   assign cur_tag    = tag_q;

   always_comb begin
      ctrl_rd = ctrl_q;
      ctrl_rd[INDEX_LSB +: FIELD_W] = FIELD_W'(idx_q);
   end

   always_comb begin
      case (rd_sel)
         SEL_CTRL: rd_data = ctrl_rd;
         SEL_VPG:  rd_data = vpg_q;
         SEL_ATTR: rd_data = attr_q;
         SEL_TAG:  rd_data = {{(32-TAG_W){1'b0}}, tag_q};
         SEL_PPG:  rd_data = ppg_q;
         default:  rd_data = '0;
      endcase
   end

   // R4: pointer steps by one below the last slot
   p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && idx_q != LAST_IDX) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));

   // R4: plain wrap goes to slot zero
   p_wrap_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && idx_q == LAST_IDX && !rsv) |=> (idx_q == '0));

   // R5: reserved wrap skips the pinned slots
   p_wrap_rsv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && idx_q == LAST_IDX && rsv) |=> (idx_q == RSV_IDX));

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
   import sw_tlb_pkg::*;
#(
   parameter int  ENTRIES = 32,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  tlb_entry_t         wr_entry,
   input  logic [PAGE_W-1:0]  lk_page,
   input  logic [TAG_W-1:0]   lk_tag,
   output logic [ENTRIES-1:0] match_vec,
   output tlb_entry_t         tbl [ENTRIES]
);

   tlb_entry_t tbl_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
      end else if (wr_en) begin
         tbl_q[wr_idx] <= wr_entry;
      end
   end

   // one comparator per slot
   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
         logic [PAGE_W-1:0] diff;
         assign diff = (tbl_q[g].vpn ^ lk_page) & cmp_mask(tbl_q[g].size);
         assign match_vec[g] = tbl_q[g].vld && (tbl_q[g].tag == lk_tag) && (diff == '0);
         assign tbl[g] = tbl_q[g];
      end
   endgenerate

   // R3: the committed entry lands in the addressed slot
   p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (tbl_q[$past(wr_idx)] == $past(wr_entry)));

   // R12: an entry committed without both valid flags never matches
   p_inval_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_entry.vld) |=> !match_vec[$past(wr_idx)]);

endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select
   import sw_tlb_pkg::*;
#(
   parameter int  ENTRIES = 32,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] match_vec,
   input  tlb_entry_t         tbl [ENTRIES],
   input  logic [PAGE_W-1:0]  lk_page,
   output logic               hit,
   output logic [PAGE_W-1:0]  ppn,
   output logic               grd,
   output logic [GRP_W-1:0]   grp,
   output logic [1:0]         size
);

   logic [IDX_W-1:0]  sel_idx;
   tlb_entry_t        e;
   logic [PAGE_W-1:0] m;

   // lowest matching slot wins
   always_comb begin
      hit     = 1'b0;
      sel_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            hit     = 1'b1;
            sel_idx = IDX_W'(i);
         end
      end
   end

   assign e = tbl[sel_idx];
   assign m = cmp_mask(e.size);

   always_comb begin
      if (hit) begin
         ppn  = (e.ppn & m) | (lk_page & ~m);
         grd  = e.grd;
         grp  = e.grp;
         size = e.size;
      end else begin
         ppn  = '0;
         grd  = 1'b0;
         grp  = '0;
         size = '0;
      end
   end

   // R10: no lower slot matched when a slot is selected
   p_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((match_vec & ((ENTRIES'(1) << sel_idx) - 1'b1)) == '0));

   // R6: a reported hit comes from a matching slot
   p_hit_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> match_vec[sel_idx]);

   // R6: a miss means no slot matched
   p_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (match_vec == '0));

endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
   import sw_tlb_pkg::*;
#(
   parameter int          ENTRIES    = 32,
   parameter int          RESERVED   = 4,
   parameter logic [31:0] CTRL_RESET = 32'h0400_0000,
   parameter int          INDEX_LSB  = 8,
   parameter int          RSV_BIT    = 27
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_sel,
   input  logic [31:0] wr_data,
   input  logic [2:0]  rd_sel,
   output logic [31:0] rd_data,
   input  logic [19:0] lk_page,
   output logic        lk_hit,
   output logic [19:0] lk_ppn,
   output logic        lk_guarded,
   output logic [3:0]  lk_group,
   output logic [1:0]  lk_size
);

   localparam int IDX_W = $clog2(ENTRIES);

   logic [TAG_W-1:0]   cur_tag;
   logic               commit;
   logic [IDX_W-1:0]   commit_idx;
   tlb_entry_t         commit_entry;
   logic [ENTRIES-1:0] match_vec;
   tlb_entry_t         tbl [ENTRIES];

   tlb_stage_regs #(
      .ENTRIES(ENTRIES), .RESERVED(RESERVED), .CTRL_RESET(CTRL_RESET),
      .INDEX_LSB(INDEX_LSB), .FIELD_W(5), .RSV_BIT(RSV_BIT)
   ) u_stage (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .cur_tag(cur_tag), .commit(commit),
      .commit_idx(commit_idx), .commit_entry(commit_entry)
   );

   tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_idx(commit_idx),
      .wr_entry(commit_entry), .lk_page(lk_page), .lk_tag(cur_tag),
      .match_vec(match_vec), .tbl(tbl)
   );

   tlb_hit_select #(.ENTRIES(ENTRIES)) u_sel (
      .clk(clk), .rst_n(rst_n), .match_vec(match_vec), .tbl(tbl), .lk_page(lk_page),
      .hit(lk_hit), .ppn(lk_ppn), .grd(lk_guarded), .grp(lk_group), .size(lk_size)
   );

endmodule

// File: tb/sim_sw_tlb.sv
module sim_sw_tlb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic [19:0] lk_page = '0;
   logic        lk_hit;
   logic [19:0] lk_ppn;
   logic        lk_guarded;
   logic [3:0]  lk_group;
   logic [1:0]  lk_size;

   int n_run  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   sw_tlb u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .lk_page(lk_page), .lk_hit(lk_hit),
      .lk_ppn(lk_ppn), .lk_guarded(lk_guarded), .lk_group(lk_group), .lk_size(lk_size)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rdchk(input logic [2:0] s, input logic [31:0] exp, input string tag);
      rd_sel = s;
      #1;
      chk(tag, rd_data, exp);
   endtask

   // exp_attr = {guarded, group[3:0], size[1:0]}
   task automatic lkchk(input logic [19:0] pg, input logic exp_hit, input logic [19:0] exp_ppn,
                        input logic [6:0] exp_attr, input string tag);
      lk_page = pg;
      #1;
      chk({tag, " hit"}, {31'b0, lk_hit}, {31'b0, exp_hit});
      if (exp_hit) begin
         chk({tag, " ppn"}, {12'b0, lk_ppn}, {12'b0, exp_ppn});
         chk({tag, " attr"}, {25'b0, lk_guarded, lk_group, lk_size}, {25'b0, exp_attr});
      end
   endtask

   initial begin
      #600000;
      n_fail++;
      $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rdchk(3'd0, 32'h0400_0000, "R1 ctrl reset");
      lkchk(20'h00000, 1'b0, '0, '0, "R1 empty lookup");

      // R2: staging readback
      wr(3'd1, 32'h1234_5A05);
      rdchk(3'd1, 32'h1234_5A05, "R2 vpage readback");
      wr(3'd2, 32'h0000_01FD);
      rdchk(3'd2, 32'h0000_01FD, "R2 attr readback");
      wr(3'd3, 32'hFFFF_FFF7);
      rdchk(3'd3, 32'h0000_0007, "R2 tag low bits only");
      wr(3'd0, 32'h0000_0000);
      rdchk(3'd0, 32'h0000_0000, "R2 ctrl readback");
      lkchk(20'h12345, 1'b0, '0, '0, "R1 still empty after staging");

      // R3/R4: fill every slot in order
      wr(3'd3, 32'd5);
      for (int i = 0; i < 32; i++) begin
         wr(3'd1, ((32'h100 + i) << 12) | 32'h200 | 32'd5);
         wr(3'd2, 32'd1 | ((i % 16) << 5) | ((i % 2) << 4));
         wr(3'd4, (32'h80000 + i) << 12);
         rdchk(3'd0, ((i + 1) % 32) << 8, "R4 pointer advance");
      end
      rdchk(3'd4, 32'h8001_F000, "R2 ppage readback");
      for (int i = 0; i < 32; i++) begin
         lkchk(20'(32'h100 + i), 1'b1, 20'(32'h80000 + i),
               {1'(i % 2), 4'(i % 16), 2'b00}, "R3 R9 filled slot");
      end

      // R6: tag sweep
      for (int a = 0; a < 16; a++) begin
         wr(3'd3, a);
         lkchk(20'h00100, (a == 5), 20'h80000, 7'b0000000, "R6 tag match");
      end
      wr(3'd3, 32'd5);

      // R5/R11: explicit write into a pinned slot
      wr(3'd0, 32'h0800_0200);
      wr(3'd1, 32'h0020_0205);
      wr(3'd2, 32'h0000_0001);
      wr(3'd4, 32'h1234_5000);
      lkchk(20'h00200, 1'b1, 20'h12345, 7'b0, "R11 new entry next cycle");
      lkchk(20'h00102, 1'b0, '0, '0, "R11 replaced entry gone");
      rdchk(3'd0, 32'h0800_0300, "R5 pinned slot advance");
      // reserved wrap
      wr(3'd0, 32'h0800_1F00);
      wr(3'd1, 32'h0030_0205);
      wr(3'd4, 32'h0AAA_A000);
      rdchk(3'd0, 32'h0800_0400, "R5 wrap to slot 4");
      lkchk(20'h00300, 1'b1, 20'h0AAAA, 7'b0, "R5 last slot loaded");
      lkchk(20'h0011F, 1'b0, '0, '0, "R5 old last entry gone");
      lkchk(20'h00100, 1'b1, 20'h80000, 7'b0, "R5 slot 0 untouched");

      // R7/R8: 512 KB page in slot 10
      wr(3'd0, 32'h0000_0A00);
      wr(3'd1, 32'h4000_0205);
      wr(3'd2, 32'h0000_0015);
      wr(3'd4, 32'h0ABC_0000);
      for (int k = 0; k < 128; k++) begin
         lkchk(20'(32'h40000 + k), 1'b1, 20'(32'h0AB80 | k), {1'b1, 4'd0, 2'b01},
               "R7 R8 512K in-page");
      end
      lkchk(20'h40080, 1'b0, '0, '0, "R7 512K boundary");
      // 8 MB page in slot 11
      wr(3'd1, 32'h8000_0205);
      wr(3'd2, 32'h0000_002D);
      wr(3'd4, 32'hFF80_0000);
      for (int k = 0; k < 128; k++) begin
         lkchk(20'(32'h80000 + (k << 4)), 1'b1, 20'(32'hFF800 | (k << 4)),
               {1'b0, 4'd1, 2'b11}, "R7 R8 8M in-page");
      end
      lkchk(20'h80800, 1'b0, '0, '0, "R7 8M boundary");
      // unassigned code in slot 12 acts as 4 KB
      wr(3'd1, 32'hC000_0205);
      wr(3'd2, 32'h0000_0009);
      wr(3'd4, 32'h1111_1000);
      lkchk(20'hC0000, 1'b1, 20'h11111, {1'b0, 4'd0, 2'b10}, "R7 code 10 exact");
      lkchk(20'hC0001, 1'b0, '0, '0, "R7 code 10 neighbour");

      // R10: duplicate page in slots 20 and 21
      wr(3'd0, 32'h0000_1500);
      wr(3'd1, 32'h0011_4205);
      wr(3'd2, 32'h0000_0001);
      wr(3'd4, 32'h7777_7000);
      lkchk(20'h00114, 1'b1, 20'h80014, {1'b0, 4'd4, 2'b00}, "R10 lowest slot wins");
      // R12: clear entry-valid in slot 20
      wr(3'd0, 32'h0000_1400);
      wr(3'd1, 32'h0011_4005);
      wr(3'd4, 32'h0000_0000);
      lkchk(20'h00114, 1'b1, 20'h77777, 7'b0, "R12 entry flag clear");
      // R12: clear segment-valid in slot 21
      wr(3'd0, 32'h0000_1500);
      wr(3'd1, 32'h0011_4205);
      wr(3'd2, 32'h0000_0000);
      wr(3'd4, 32'h7777_7000);
      lkchk(20'h00114, 1'b0, '0, '0, "R12 segment flag clear");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule